// File: doc/BRIEF.md
# Edge-Aligned Radio Bit Serializer

This block relieves a byte-oriented processor of per-bit work on a raw on-off-keyed radio data line. On receive, the processor detects the start pattern in software and then pulses an arm input. The block timestamps the next rising edge of the line against a free-running counter. It uses that edge to phase a bit-period counter, samples each later bit in mid-period and assembles bytes MSB first. The processor then picks up each byte through a valid/ready handshake. Bit timing comes only from the captured edge and never passes through the processor's data path.

On transmit, the processor preloads a 16-bit start pattern and a delay counted in bit periods, then starts the frame. The block keeps the line low for the delay, sends the pattern, and then sends data bytes from a one-byte holding buffer that the processor refills whenever it signals empty. If the buffer is still empty when a byte or the pattern finishes, the frame ends and the line returns low. With the default parameters a bit lasts 80 clock cycles, which is 20 us at 4 MHz, or 50 kb/s.

Top module: `rbs_serializer`

## Requirements
- R1: A 16-bit counter is zero in reset and increments every cycle. `stamp` takes the counter value present in the cycle where `rf_rx` is first seen high after being low, following a `sync_arm` pulse. `stamp_valid` then rises, and later edges leave `stamp` unchanged.
- R2: The captured edge marks a bit boundary. The bit period that begins there is a sync mark and is discarded. Data bit k (k from 0) is sampled at the clock edge BIT_CYC*(k+1)+SAMPLE_AT cycles after the capturing edge, which is 80*(k+1)+40 with the defaults.
- R3: Received bits fill a byte MSB first. After every eighth data bit, `rx_byte` holds the byte and `rx_valid` rises. `rx_valid` stays high until a cycle where both `rx_valid` and `rx_ready` are high.
- R4: If a byte completes while `rx_valid` is high and no read happens in that cycle, `rx_overrun` is set and `rx_byte` takes the new byte. A read clears `rx_overrun`. A read in the same cycle a byte completes delivers the new byte with `rx_valid` kept high and no overrun.
- R5: After reset, `rf_tx`, `tx_busy`, `rx_valid`, `rx_overrun` and `stamp_valid` are 0, `stamp` is 0 and `tx_ready` is 1.
- R6: A `tx_start` pulse while idle raises `tx_busy`. The line is held low for `tx_delay` bit periods, with 0 meaning no delay. The 16-bit `tx_symbol` is then sent MSB first, with each bit lasting BIT_CYC cycles and the line changing only at bit boundaries.
- R7: `tx_ready` high means the one-byte buffer is empty. A cycle with `tx_valid` and `tx_ready` both high stores `tx_data` and drops `tx_ready`. Stored bytes follow the pattern MSB first, back to back with no gap.
- R8: If the buffer is empty when the pattern or a data byte finishes, `tx_busy` falls and `rf_tx` is low from the next bit boundary on.
- R9: `tx_start` while `tx_busy` is high has no effect on the frame in progress.
- R10: `sync_arm` clears `stamp_valid` and `rx_overrun` and stops sampling. No byte is produced until a new rising edge restarts alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_rx | input | 1 | Raw receive data line, already synchronous |
| sync_arm | input | 1 | Start pattern found; capture the next rising edge |
| stamp | output | 16 | Counter value at the captured edge |
| stamp_valid | output | 1 | `stamp` holds a capture since the last arm |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Processor takes the byte |
| rx_overrun | output | 1 | A byte was replaced before being read |
| tx_start | input | 1 | Begin a transmit frame |
| tx_delay | input | 16 | Delay before the pattern, in bit periods |
| tx_symbol | input | 16 | Start pattern, sent MSB first |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmit buffer empty |
| tx_busy | output | 1 | Frame in progress |
| rf_tx | output | 1 | Transmit data line |

## Verification
The processor's read of a pending byte and the completion of the next byte can land on the same clock edge. The bench provokes this by leaving one byte unread and then raising `rx_ready` for exactly the cycle of the eighth mid-bit sample of the following byte. It judges the result by requiring `rx_valid` still high, `rx_byte` equal to the newer byte and `rx_overrun` low. The bench also runs the opposite case, where a byte completes with no read, and expects the overrun flag.

// File: rtl/rbs_pkg.sv
// Shared types and constants for the radio bit serializer.
// Assumes a byte-wide processor side.
package rbs_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_WAIT = 2'd1,
        TX_SYM  = 2'd2,
        TX_DATA = 2'd3
    } tx_state_e;

endpackage

// File: rtl/rbs_stamp.sv
// Edge timestamp unit: runs a free counter and latches it on the first rising
// edge of the receive line after an arm pulse.
// Assumes rf_rx is already synchronous to clk.
module rbs_stamp #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rf_rx,
    input  logic            arm,
    output logic            capture,
    output logic [TS_W-1:0] stamp,
    output logic            stamp_valid
);

    logic [TS_W-1:0] tsc_q;
    logic            line_q;
    logic            hunt_q;

    // Free-running time base.
    always_ff @(posedge clk) begin
        if (!rst_n) tsc_q <= '0;
        else        tsc_q <= tsc_q + 1'b1;
    end

    // Previous line level, used to find rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= rf_rx;
    end

    assign capture = hunt_q && rf_rx && !line_q && !arm;

    // Hunting flag: set by arm, cleared once an edge is captured.
    always_ff @(posedge clk) begin
        if (!rst_n)       hunt_q <= 1'b0;
        else if (arm)     hunt_q <= 1'b1;
        else if (capture) hunt_q <= 1'b0;
    end

    // Timestamp register and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp       <= '0;
            stamp_valid <= 1'b0;
        end else if (arm) begin
            stamp_valid <= 1'b0;
        end else if (capture) begin
            stamp       <= tsc_q;
            stamp_valid <= 1'b1;
        end
    end

    // R1: a held stamp is not disturbed by later edges
    p_stamp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (stamp_valid && !arm) |=> (stamp_valid && $stable(stamp)));

    // R10: arming always withdraws the stamp
    p_arm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !stamp_valid);

endmodule

// File: rtl/rbs_rx_shift.sv
// Receive bit engine: a phase counter aligned on the captured edge, a sample
// strobe in mid-period, an MSB-first shifter and the byte handshake with
// overrun detection. The first period after the edge is a sync mark.
module rbs_rx_shift #(
    parameter int BIT_CYC   = 80,
    parameter int SAMPLE_AT = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rf_rx,
    input  logic                       arm,
    input  logic                       capture,
    input  logic                       rd_ready,
    output logic [rbs_pkg::BYTE_W-1:0] rx_byte,
    output logic                       rx_valid,
    output logic                       rx_overrun
);
    import rbs_pkg::*;

    localparam int PH_W = $clog2(BIT_CYC);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYC - 1);
    localparam logic [PH_W-1:0] PH_SMP  = PH_W'(SAMPLE_AT);
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(BYTE_W - 1);

    logic              lock_q;
    logic              skip_q;
    logic [PH_W-1:0]   ph_q;
    logic [BC_W-1:0]   bc_q;
    logic [BYTE_W-1:0] sh_q;
    logic              strobe;
    logic              done;
    logic              rd;

    assign strobe = lock_q && (ph_q == PH_SMP);
    assign done   = strobe && !skip_q && (bc_q == BC_LAST);
    assign rd     = rx_valid && rd_ready;

    // Lock state, phase counter and sync-mark skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            skip_q <= 1'b0;
            ph_q   <= '0;
        end else if (arm) begin
            lock_q <= 1'b0;
        end else if (capture) begin
            lock_q <= 1'b1;
            skip_q <= 1'b1;
            ph_q   <= PH_W'(1);
        end else if (lock_q) begin
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
            if (strobe) skip_q <= 1'b0;
        end
    end

    // Bit counter and shifter, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bc_q <= '0;
            sh_q <= '0;
        end else if (capture) begin
            bc_q <= '0;
        end else if (strobe && !skip_q) begin
            sh_q <= {sh_q[BYTE_W-2:0], rf_rx};
            bc_q <= (bc_q == BC_LAST) ? '0 : bc_q + 1'b1;
        end
    end

    // Output byte, ready flag and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte    <= '0;
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            if (done) begin
                rx_byte  <= {sh_q[BYTE_W-2:0], rf_rx};
                rx_valid <= 1'b1;
            end else if (rd) begin
                rx_valid <= 1'b0;
            end
            if (arm)                         rx_overrun <= 1'b0;
            else if (done && rx_valid && !rd) rx_overrun <= 1'b1;
            else if (rd)                     rx_overrun <= 1'b0;
        end
    end

    // R3: an unread byte stays offered
    p_valid_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_ready) |=> rx_valid);

    // R4: overrun only appears when a byte was already waiting
    p_overrun_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_valid));

    // R10: nothing is delivered while hunting for a new edge
    p_no_byte_unlocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && !rd_ready) |=> $stable(rx_byte));

endmodule

// File: rtl/rbs_tx.sv
// Transmit engine: delay in bit periods, start pattern, then buffered data
// bytes MSB first. The frame ends when the buffer is empty at a byte edge.
// Assumes SYM_W >= BYTE_W.
module rbs_tx #(
    parameter int BIT_CYC = 80,
    parameter int SYM_W   = 16,
    parameter int DLY_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tx_start,
    input  logic [DLY_W-1:0]           tx_delay,
    input  logic [SYM_W-1:0]           tx_symbol,
    input  logic [rbs_pkg::BYTE_W-1:0] tx_data,
    input  logic                       tx_valid,
    output logic                       tx_ready,
    output logic                       tx_busy,
    output logic                       rf_tx
);
    import rbs_pkg::*;

    localparam int BT_W  = $clog2(BIT_CYC);
    localparam int CNT_W = $clog2(SYM_W + 1);
    localparam logic [BT_W-1:0]  BT_LAST  = BT_W'(BIT_CYC - 1);
    localparam logic [CNT_W-1:0] SYM_LAST = CNT_W'(SYM_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(BYTE_W - 1);

    tx_state_e         state_q;
    logic [BT_W-1:0]   bt_q;
    logic [DLY_W-1:0]  dly_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SYM_W-1:0]  sh_q;
    logic [BYTE_W-1:0] buf_q;
    logic              full_q;
    logic              bit_end;
    logic              last_bit;
    logic              sending;
    logic              load;
    logic              wr;

    assign sending  = (state_q == TX_SYM) || (state_q == TX_DATA);
    assign bit_end  = (bt_q == BT_LAST);
    assign last_bit = ((state_q == TX_SYM)  && (cnt_q == SYM_LAST)) ||
                      ((state_q == TX_DATA) && (cnt_q == DAT_LAST));
    assign load     = sending && bit_end && last_bit && full_q;
    assign wr       = tx_valid && !full_q;

    // Frame sequencer: delay, pattern, data, end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            bt_q    <= '0;
            dly_q   <= '0;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    if (tx_start) begin
                        bt_q  <= '0;
                        cnt_q <= '0;
                        sh_q  <= tx_symbol;
                        dly_q <= tx_delay;
                        state_q <= (tx_delay == '0) ? TX_SYM : TX_WAIT;
                    end
                end
                TX_WAIT: begin
                    if (bit_end) begin
                        bt_q <= '0;
                        if (dly_q == DLY_W'(1)) state_q <= TX_SYM;
                        else                    dly_q   <= dly_q - 1'b1;
                    end else begin
                        bt_q <= bt_q + 1'b1;
                    end
                end
                TX_SYM, TX_DATA: begin
                    if (bit_end) begin
                        bt_q <= '0;
                        if (last_bit) begin
                            cnt_q <= '0;
                            if (full_q) begin
                                state_q <= TX_DATA;
                                sh_q    <= {buf_q, {(SYM_W - BYTE_W){1'b0}}};
                            end else begin
                                state_q <= TX_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            sh_q  <= {sh_q[SYM_W-2:0], 1'b0};
                        end
                    end else begin
                        bt_q <= bt_q + 1'b1;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    // One-byte holding buffer between processor and shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q  <= '0;
            full_q <= 1'b0;
        end else begin
            if (wr) buf_q <= tx_data;
            full_q <= load ? 1'b0 : (full_q || wr);
        end
    end

    assign tx_ready = !full_q;
    assign tx_busy  = (state_q != TX_IDLE);
    assign rf_tx    = sending && sh_q[SYM_W-1];

    // R6: the line moves only on bit boundaries while sending
    p_bit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sending && !bit_end) |=> $stable(rf_tx));

    // R7: an accepted byte fills the buffer
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R8: a frame only ends with the buffer empty
    p_end_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> $past(tx_ready));

    // R9: a start request mid-frame keeps the frame running
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && tx_start && !(sending && bit_end)) |=> tx_busy);

endmodule

// File: rtl/rbs_serializer.sv
// Top level of the edge-aligned radio bit serializer: connects the edge
// timestamp unit, the receive bit engine and the transmit engine.
// Assumes rf_rx is synchronous and one bit spans BIT_CYC clock cycles.
module rbs_serializer #(
    parameter int BIT_CYC   = 80,
    parameter int SAMPLE_AT = 40,
    parameter int TS_W      = 16,
    parameter int SYM_W     = 16,
    parameter int DLY_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rf_rx,
    input  logic             sync_arm,
    output logic [TS_W-1:0]  stamp,
    output logic             stamp_valid,
    output logic [7:0]       rx_byte,
    output logic             rx_valid,
    input  logic             rx_ready,
    output logic             rx_overrun,
    input  logic             tx_start,
    input  logic [DLY_W-1:0] tx_delay,
    input  logic [SYM_W-1:0] tx_symbol,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             tx_busy,
    output logic             rf_tx
);

    logic capture;

    rbs_stamp #(.TS_W(TS_W)) stamp_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rf_rx       (rf_rx),
        .arm         (sync_arm),
        .capture     (capture),
        .stamp       (stamp),
        .stamp_valid (stamp_valid)
    );

    rbs_rx_shift #(.BIT_CYC(BIT_CYC), .SAMPLE_AT(SAMPLE_AT)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rf_rx      (rf_rx),
        .arm        (sync_arm),
        .capture    (capture),
        .rd_ready   (rx_ready),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .rx_overrun (rx_overrun)
    );

    rbs_tx #(.BIT_CYC(BIT_CYC), .SYM_W(SYM_W), .DLY_W(DLY_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_start  (tx_start),
        .tx_delay  (tx_delay),
        .tx_symbol (tx_symbol),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_busy   (tx_busy),
        .rf_tx     (rf_tx)
    );

endmodule

// File: tb/rbs_serializer_tb_top.sv
// Self-checking bench: random bytes, delays and patterns from a fixed seed,
// plus directed cases for overrun, same-cycle read and empty frames.
module rbs_serializer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rf_rx = 1'b0;
    logic        sync_arm = 1'b0;
    logic [15:0] stamp;
    logic        stamp_valid;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic        rx_ready = 1'b0;
    logic        rx_overrun;
    logic        tx_start = 1'b0;
    logic [15:0] tx_delay = '0;
    logic [15:0] tx_symbol = '0;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        tx_busy;
    logic        rf_tx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int unsigned seed_val;

    always #5 clk = ~clk;

    // Bench copy of elapsed cycles since reset release.
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    rbs_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .rf_rx(rf_rx), .sync_arm(sync_arm),
        .stamp(stamp), .stamp_valid(stamp_valid), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
        .tx_start(tx_start), .tx_delay(tx_delay), .tx_symbol(tx_symbol),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_busy(tx_busy), .rf_tx(rf_tx)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected transmit line level for frame bit j.
    function automatic logic tx_exp(input int j, input int d, input logic [15:0] sym,
                                    input int nb, input logic [7:0] b0, input logic [7:0] b1,
                                    input logic [7:0] b2, input logic [7:0] b3);
        int k;
        logic [7:0] cur;
        if (j < d) return 1'b0;
        if (j < d + 16) return sym[15 - (j - d)];
        k = j - d - 16;
        if (k >= nb * 8) return 1'b0;
        case (k / 8)
            0: cur = b0;
            1: cur = b1;
            2: cur = b2;
            default: cur = b3;
        endcase
        return cur[7 - (k % 8)];
    endfunction

    function automatic logic ovr_exp(input int mode, input int b);
        return (mode == 1) && (b > 0);
    endfunction

    task automatic arm_pulse();
        @(negedge clk) sync_arm = 1'b1;
        @(negedge clk) sync_arm = 1'b0;
    endtask

    // Receive one frame. mode 0: read each byte; 1: never read; 2: read in the
    // same cycle as the next byte completes.
    task automatic rx_frame(input int nb, input int mode);
        logic [7:0]  bytes [4];
        logic [15:0] exp_stamp;
        for (int b = 0; b < 4; b++) bytes[b] = 8'($urandom);
        arm_pulse();
        chk("R10", "stamp_valid after arm", 32'(stamp_valid), 0);
        repeat ($urandom_range(2, 30)) @(negedge clk);
        rf_rx = 1'b1;
        exp_stamp = 16'(cyc);
        repeat (80) @(posedge clk);
        @(negedge clk);
        chk("R1", "stamp_valid", 32'(stamp_valid), 1);
        chk("R1", "stamp", 32'(stamp), 32'(exp_stamp));
        for (int b = 0; b < nb; b++) begin
            for (int i = 0; i < 8; i++) begin
                rf_rx = bytes[b][7 - i];
                repeat (40) @(posedge clk);
                @(negedge clk);
                if (i == 7 && mode == 2 && b > 0) rx_ready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                rx_ready = 1'b0;
                if (i == 7) begin
                    chk("R3", "rx_valid after byte", 32'(rx_valid), 1);
                    chk("R2", "rx_byte", 32'(rx_byte), 32'(bytes[b]));
                    chk("R4", "rx_overrun", 32'(rx_overrun), 32'(ovr_exp(mode, b)));
                    rx_ready = (mode == 0);
                end
                @(posedge clk);
                @(negedge clk);
                rx_ready = 1'b0;
                if (i == 7 && mode == 0) chk("R3", "rx_valid after read", 32'(rx_valid), 0);
                repeat (38) @(posedge clk);
                @(negedge clk);
            end
        end
        chk("R1", "stamp held after edges", 32'(stamp), 32'(exp_stamp));
        rf_rx = 1'b0;
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        chk("R4", "rx_valid cleared by read", 32'(rx_valid), 0);
        chk("R4", "overrun cleared by read", 32'(rx_overrun), 0);
        arm_pulse();
    endtask

    // Transmit one frame with delay d and nb data bytes.
    task automatic tx_frame(input int d, input int nb);
        logic [15:0] sym;
        logic [7:0]  bytes [4];
        int total;
        sym = 16'($urandom);
        for (int b = 0; b < 4; b++) bytes[b] = 8'($urandom);
        total = d + 16 + nb * 8;
        if (nb > 0) begin
            @(negedge clk);
            tx_data = bytes[0];
            tx_valid = 1'b1;
            @(negedge clk);
            tx_valid = 1'b0;
            chk("R7", "tx_ready after write", 32'(tx_ready), 0);
        end
        @(negedge clk);
        tx_delay = 16'(d);
        tx_symbol = sym;
        tx_start = 1'b1;
        @(posedge clk);
        fork
            begin
                @(negedge clk) tx_start = 1'b0;
                for (int j = 0; j <= total; j++) begin
                    repeat (40) @(posedge clk);
                    @(negedge clk);
                    chk((j < d + 16) ? "R6" : (j < total ? "R7" : "R8"), "rf_tx",
                        32'(rf_tx),
                        32'(tx_exp(j, d, sym, nb, bytes[0], bytes[1], bytes[2], bytes[3])));
                    chk("R8", "tx_busy", 32'(tx_busy), (j == total) ? 0 : 1);
                    if (j == d + 3) tx_start = 1'b1;   // R9: start while busy
                    @(posedge clk);
                    @(negedge clk) tx_start = 1'b0;
                    repeat (39) @(posedge clk);
                end
            end
            begin
                for (int b = 1; b < nb; b++) begin
                    @(negedge clk);
                    while (!tx_ready) @(negedge clk);
                    tx_data = bytes[b];
                    tx_valid = 1'b1;
                    @(negedge clk);
                    tx_valid = 1'b0;
                end
            end
        join
    endtask

    // Watchdog: a hung run still reports.
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seed_val = $urandom(32'd20240611);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R5", "rf_tx", 32'(rf_tx), 0);
        chk("R5", "tx_busy", 32'(tx_busy), 0);
        chk("R5", "tx_ready", 32'(tx_ready), 1);
        chk("R5", "rx_valid", 32'(rx_valid), 0);
        chk("R5", "rx_overrun", 32'(rx_overrun), 0);
        chk("R5", "stamp_valid", 32'(stamp_valid), 0);
        chk("R5", "stamp", 32'(stamp), 0);
        rst_n = 1'b1;

        rx_frame(2, 0);
        rx_frame(1, 0);
        for (int n = 0; n < 3; n++) rx_frame(int'($urandom_range(1, 4)), 0);
        rx_frame(3, 1);
        rx_frame(3, 2);

        // R10: armed with the line idle, no byte appears
        repeat (800) @(negedge clk);
        chk("R10", "rx_valid while hunting", 32'(rx_valid), 0);
        chk("R10", "stamp_valid while hunting", 32'(stamp_valid), 0);

        tx_frame(0, 0);
        tx_frame(0, 1);
        tx_frame(2, 3);
        for (int n = 0; n < 3; n++)
            tx_frame(int'($urandom_range(0, 3)), int'($urandom_range(1, 4)));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule